// File: doc/BRIEF.md
# Link-Layer Replay Transmitter

This block is the transmit half of a reliable link layer. Packets arrive one byte per cycle on a valid/ready input with an end-of-packet flag. Each packet is stored in a small replay buffer, given the next sequence number and sent on a byte-wide framed output. Each frame carries a two-byte sequence field, then the packet bytes, then a 32-bit link CRC. A frame is only sent once its whole packet has been stored.

The far end returns acknowledge and negative-acknowledge indications, each naming a sequence number. An acknowledge is cumulative: it frees the named packet and every older one. A negative acknowledge frees the packets older than the one it names and rewinds transmission to that packet. A timer that expires with packets still unacknowledged also rewinds transmission, to the oldest one. In both cases every outstanding packet is sent again in order (go-back-N). New packets are held off while the buffer is full and while a replay is running.

Top module: `link_replay_tx`

## Requirements
- R1: A frame is driven on consecutive cycles with `outValid` high throughout, and `outLast` marks only its final byte. The frame is the high sequence byte, the low sequence byte, the packet bytes in input order, then four CRC bytes. At least one idle cycle separates frames.
- R2: The first packet after reset gets sequence number 0, and each new packet gets the previous number plus one, modulo 4096. The 12-bit number sits in the low bits of the 16-bit field and the top 4 bits are zero.
- R3: The CRC uses generator 0x04C11DB7. The register starts at all ones and takes each byte most significant bit first. It covers both sequence bytes and the packet bytes. The complemented result is sent most significant byte first.
- R4: With 4 packets stored and not yet acknowledged, `inReady` is low.
- R5: A valid acknowledge naming N frees packet N and all older outstanding packets. `inReady` rises in the cycle after the acknowledge if it was held low only by a full buffer.
- R6: A valid negative acknowledge naming N frees the packets older than N. It then retransmits every packet from N up to the newest one sent, in order and with the same contents.
- R7: If packets are outstanding and no packet is sent and no indication is accepted for `TIMEOUT_CYCLES` cycles, every outstanding packet is retransmitted in order. No retransmission happens before that.
- R8: An acknowledge or negative acknowledge is valid only if its number lies between the oldest outstanding packet and the last packet sent in the current pass. Any other indication frees nothing and starts no retransmission.
- R9: From the cycle after a replay begins until the last replayed frame has ended, `inReady` is low.
- R10: Out of reset `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input packet byte |
| inLast | input | 1 | Input byte ends its packet |
| inReady | output | 1 | Block can take the input byte |
| outValid | output | 1 | Output frame byte valid |
| outData | output | 8 | Output frame byte |
| outLast | output | 1 | Final byte of a frame |
| ackValid | input | 1 | Acknowledge indication present |
| ackIsNak | input | 1 | Indication is a negative acknowledge |
| ackSeq | input | 12 | Sequence number named by the indication |

## Verification
The assertions assume that no packet exceeds 64 bytes and that a byte offered on the input stays unchanged until it is taken. They also assume that an indication lasts one cycle and that the downstream side takes every frame byte without stalling. The stimulus keeps packets between 1 and 64 bytes and holds each byte until `inReady` accepts it. It presents every indication for exactly one cycle, including the deliberately stale or out-of-window numbers that the block must ignore.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam int SLOT_FIELD_W = 8;
  localparam int SEQ_FIELD_W  = 16;
  localparam logic [31:0] CRC_GEN = 32'h04C11DB7;

  typedef enum logic [1:0] {PH_SEQ, PH_PAY, PH_CRC} phase_t;

  typedef struct packed {
    logic                    wrEn;
    logic                    wrLast;
    logic [SLOT_FIELD_W-1:0] wrSlot;
    logic                    txStart;
    logic [SLOT_FIELD_W-1:0] txSlot;
    logic [SEQ_FIELD_W-1:0]  txSeq;
  } strobe_t;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ CRC_GEN;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/lrt_datapath.sv
module lrt_datapath
  import lrt_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int MAX_BYTES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [7:0]    inData,
  output logic          outValid,
  output logic [7:0]    outData,
  output logic          outLast,
  output logic          txBusy,
  output logic          txDone
);
  localparam int LEN_W  = $clog2(MAX_BYTES + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DEPTH  = SLOTS * MAX_BYTES;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [7:0]        mem    [DEPTH];
  logic [LEN_W-1:0]  lenMem [SLOTS];
  logic [LEN_W-1:0]  wrPos;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  logic              busy;
  phase_t            phase;
  logic [LEN_W-1:0]  pos;
  logic [SLOT_W-1:0] slotR;
  logic [15:0]       seqR;
  logic [31:0]       crcR, crcFin;
  logic [7:0]        curByte;

  assign wrAddr = ADDR_W'(strb.wrSlot) * ADDR_W'(MAX_BYTES) + ADDR_W'(wrPos);
  assign rdAddr = ADDR_W'(slotR) * ADDR_W'(MAX_BYTES) + ADDR_W'(pos);
  assign crcFin = ~crcR;

  // Packet store: byte array plus per-slot length
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      mem[wrAddr] <= inData;
      if (strb.wrLast) lenMem[SLOT_W'(strb.wrSlot)] <= wrPos + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     wrPos <= '0;
    else if (strb.wrEn)            wrPos <= strb.wrLast ? '0 : wrPos + LEN_W'(1);
  end

  // Frame byte selection
  always_comb begin
    case (phase)
      PH_SEQ:  curByte = pos[0] ? seqR[7:0] : seqR[15:8];
      PH_PAY:  curByte = mem[rdAddr];
      default: curByte = 8'(crcFin >> {~pos[1:0], 3'b000});
    endcase
  end

  assign txBusy   = busy;
  assign txDone   = busy && (phase == PH_CRC) && (pos[1:0] == 2'd3);
  assign outValid = busy;
  assign outData  = curByte;
  assign outLast  = txDone;

  // Frame sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= PH_SEQ;
      pos   <= '0;
      slotR <= '0;
      seqR  <= '0;
      crcR  <= '1;
    end else if (!busy) begin
      if (strb.txStart) begin
        busy  <= 1'b1;
        phase <= PH_SEQ;
        pos   <= '0;
        slotR <= SLOT_W'(strb.txSlot);
        seqR  <= strb.txSeq;
        crcR  <= '1;
      end
    end else begin
      if (phase != PH_CRC) crcR <= crcByte(crcR, curByte);
      case (phase)
        PH_SEQ: begin
          if (pos[0]) begin phase <= PH_PAY; pos <= '0; end
          else pos <= pos + LEN_W'(1);
        end
        PH_PAY: begin
          if (pos == lenMem[slotR] - LEN_W'(1)) begin phase <= PH_CRC; pos <= '0; end
          else pos <= pos + LEN_W'(1);
        end
        default: begin
          if (pos[1:0] == 2'd3) busy <= 1'b0;
          else pos <= pos + LEN_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/lrt_ctrl.sv
module lrt_ctrl
  import lrt_pkg::*;
#(
  parameter int SEQ_W          = 12,
  parameter int SLOTS          = 4,
  parameter int TIMEOUT_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic             ackValid,
  input  logic             ackIsNak,
  input  logic [SEQ_W-1:0] ackSeq,
  input  logic             txBusy,
  input  logic             txDone,
  output strobe_t          strb
);
  localparam int TMR_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int SLOT_W = $clog2(SLOTS);

  // ackedSeq <= sentSeq <= topSeq <= wrSeq, all modulo 2**SEQ_W
  logic [SEQ_W-1:0] wrSeq, ackedSeq, sentSeq, topSeq, ackedNext;
  logic [SEQ_W-1:0] bufCnt, ackOff, sentOff;
  logic             replayPend, accept, ackHit, nakHit;
  logic             outstanding, tmrFire, replayReq, replayGo, txStart;
  logic [TMR_W-1:0] tmr;

  assign bufCnt  = wrSeq - ackedSeq;
  assign inReady = (sentSeq == topSeq) && (bufCnt < SEQ_W'(SLOTS));
  assign accept  = inValid && inReady;

  assign ackOff  = ackSeq - ackedSeq;
  assign sentOff = sentSeq - ackedSeq;
  assign ackHit  = ackValid && (ackOff < sentOff);
  assign nakHit  = ackHit && ackIsNak;

  always_comb begin
    ackedNext = ackedSeq;
    if (ackHit) ackedNext = ackIsNak ? ackSeq : ackSeq + SEQ_W'(1);
  end

  assign outstanding = (topSeq != ackedSeq);
  assign tmrFire     = outstanding && !txDone && !ackHit &&
                       (tmr == TMR_W'(TIMEOUT_CYCLES - 1));
  assign replayReq   = replayPend || nakHit || tmrFire;
  assign replayGo    = replayReq && !txBusy;
  assign txStart     = !txBusy && !replayGo && (sentSeq != wrSeq);

  always_comb begin
    strb         = '0;
    strb.wrEn    = accept;
    strb.wrLast  = inLast;
    strb.wrSlot  = SLOT_FIELD_W'(wrSeq[SLOT_W-1:0]);
    strb.txStart = txStart;
    strb.txSlot  = SLOT_FIELD_W'(sentSeq[SLOT_W-1:0]);
    strb.txSeq   = SEQ_FIELD_W'(sentSeq);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSeq      <= '0;
      ackedSeq   <= '0;
      sentSeq    <= '0;
      topSeq     <= '0;
      replayPend <= 1'b0;
      tmr        <= '0;
    end else begin
      if (accept && inLast) wrSeq <= wrSeq + SEQ_W'(1);
      ackedSeq   <= ackedNext;
      replayPend <= replayReq && !replayGo;
      if (replayGo) sentSeq <= ackedNext;
      else if (txDone) begin
        sentSeq <= sentSeq + SEQ_W'(1);
        if (sentSeq == topSeq) topSeq <= topSeq + SEQ_W'(1);
      end
      if (!outstanding || txDone || ackHit || tmrFire) tmr <= '0;
      else tmr <= tmr + TMR_W'(1);
    end
  end
endmodule

// File: rtl/link_replay_tx.sv
module link_replay_tx
  import lrt_pkg::*;
#(
  parameter int SEQ_W          = 12,
  parameter int SLOTS          = 4,
  parameter int MAX_BYTES      = 64,
  parameter int TIMEOUT_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inLast,
  output logic             inReady,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outLast,
  input  logic             ackValid,
  input  logic             ackIsNak,
  input  logic [SEQ_W-1:0] ackSeq
);
  strobe_t strb;
  logic    txBusy, txDone, txStart;

  assign txStart = strb.txStart;

  lrt_ctrl #(
    .SEQ_W(SEQ_W), .SLOTS(SLOTS), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .ackValid(ackValid), .ackIsNak(ackIsNak), .ackSeq(ackSeq),
    .txBusy(txBusy), .txDone(txDone), .strb(strb)
  );

  lrt_datapath #(
    .SLOTS(SLOTS), .MAX_BYTES(MAX_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .txBusy(txBusy), .txDone(txDone)
  );
endmodule

// File: rtl/lrt_checker.sv
module lrt_checker #(
  parameter int SEQ_W = 12
) (
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       txStart
);
  p_last_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_frame_gapless_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> outValid);

  p_gap_after_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);

  p_start_from_ctrl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(txStart));

  p_seq_hi_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> (outValid && ((outData >> (SEQ_W - 8)) == 8'd0)));
endmodule

bind link_replay_tx lrt_checker #(.SEQ_W(SEQ_W)) chk_i (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outData(outData),
  .outLast(outLast), .txStart(txStart)
);

// File: tb/link_replay_tx_tb.sv
module link_replay_tx_tb_top;
  localparam int TMO = 200;
  localparam logic [15:0] PKT_TBL [6] = '{
    {8'd1, 8'h11}, {8'd5, 8'hA0}, {8'd64, 8'h3C},
    {8'd17, 8'hF0}, {8'd2, 8'h00}, {8'd9, 8'h7E}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, ackValid = 1'b0, ackIsNak = 1'b0;
  logic [7:0]  inData = '0;
  logic [11:0] ackSeq = '0;
  logic inReady, outValid, outLast;
  logic [7:0] outData;

  always #5 clk = ~clk;

  link_replay_tx #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outLast(outLast),
    .ackValid(ackValid), .ackIsNak(ackIsNak), .ackSeq(ackSeq)
  );

  int checks = 0, errors = 0;
  logic [7:0] frB [32][80];
  int frL [32];
  int frCnt = 0, curL = 0;
  int lenOf [16];
  logic [7:0] seedOf [16];

  // Frame monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (curL < 80) frB[frCnt % 32][curL] = outData;
      curL++;
      if (outLast) begin
        frL[frCnt % 32] = curL;
        curL = 0;
        frCnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input logic [7:0] seed, input int k);
    return seed + 8'(k * 37);
  endfunction

  function automatic logic [31:0] crcAdd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[31] ^ b[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic checkFrame(input int idx, input int seq, input int len,
                            input logic [7:0] seed, input string req);
    logic [7:0] e [80];
    logic [31:0] c;
    int slot, bad;
    slot = idx % 32;
    e[0] = {4'h0, 4'(seq >> 8)};
    e[1] = 8'(seq);
    for (int k = 0; k < len; k++) e[2 + k] = pb(seed, k);
    c = '1;
    for (int k = 0; k < len + 2; k++) c = crcAdd(c, e[k]);
    c = ~c;
    e[len + 2] = c[31:24]; e[len + 3] = c[23:16];
    e[len + 4] = c[15:8];  e[len + 5] = c[7:0];
    if (frL[slot] != len + 6) chk(1'b0, req, "frame length", frL[slot], len + 6);
    else begin
      bad = -1;
      for (int k = 0; k < len + 6; k++)
        if (bad < 0 && frB[slot][k] !== e[k]) bad = k;
      if (bad < 0) chk(1'b1, req, "frame", 0, 0);
      else chk(1'b0, req, $sformatf("frame seq %0d byte %0d", seq, bad), frB[slot][bad], e[bad]);
    end
  endtask

  task automatic sendPkt(input int len, input logic [7:0] seed);
    for (int k = 0; k < len; k++) begin
      inValid = 1'b1; inData = pb(seed, k); inLast = (k == len - 1);
      #1;
      while (!inReady) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic sendAck(input int seq, input bit nak);
    ackValid = 1'b1; ackIsNak = nak; ackSeq = 12'(seq);
    @(negedge clk);
    ackValid = 1'b0; ackIsNak = 1'b0;
  endtask

  task automatic waitFrames(input int target);
    int n;
    n = 0;
    while (frCnt < target && n < 5000) begin @(posedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int base, s, mism;
    logic [15:0] wrapField;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(outValid == 1'b0, "R10", "outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R10", "inReady after reset", inReady, 1);
    @(negedge clk);

    // Table-driven frames, each acknowledged (R1 R2 R3 R5)
    for (int i = 0; i < 6; i++) begin
      base = frCnt;
      lenOf[i] = int'(PKT_TBL[i][15:8]); seedOf[i] = PKT_TBL[i][7:0];
      sendPkt(lenOf[i], seedOf[i]);
      waitFrames(base + 1);
      checkFrame(base, i, lenOf[i], seedOf[i], "R1 R2 R3");
      sendAck(i, 1'b0);
    end

    // Fill the buffer: sequences 6..9 (R4)
    base = frCnt;
    for (int i = 6; i < 10; i++) begin
      lenOf[i] = 3; seedOf[i] = 8'(i * 19);
      sendPkt(lenOf[i], seedOf[i]);
    end
    waitFrames(base + 4);
    for (int i = 0; i < 4; i++) checkFrame(base + i, 6 + i, 3, seedOf[6 + i], "R2");
    #1;
    chk(inReady == 1'b0, "R4", "inReady with 4 unacked", inReady, 0);
    @(negedge clk);

    // Out-of-window indications ignored (R8)
    base = frCnt;
    sendAck(100, 1'b0);
    sendAck(100, 1'b1);
    sendAck(10, 1'b0);
    repeat (20) @(negedge clk);
    #1;
    chk(frCnt == base, "R8", "frames after stale indications", frCnt, base);
    chk(inReady == 1'b0, "R8", "inReady after stale indications", inReady, 0);
    @(negedge clk);

    // Cumulative acknowledge frees 6 and 7 (R5)
    sendAck(7, 1'b0);
    #1;
    chk(inReady == 1'b1, "R5", "inReady after ack 7", inReady, 1);
    @(negedge clk);

    // Negative acknowledge replays 8 and 9 (R6 R9)
    base = frCnt;
    sendAck(8, 1'b1);
    #1;
    chk(inReady == 1'b0, "R9", "inReady during replay", inReady, 0);
    @(negedge clk);
    waitFrames(base + 2);
    chk(frCnt == base + 2, "R6", "replayed frame count", frCnt, base + 2);
    checkFrame(base, 8, 3, seedOf[8], "R6");
    checkFrame(base + 1, 9, 3, seedOf[9], "R6");
    #1;
    chk(inReady == 1'b1, "R9", "inReady after replay", inReady, 1);
    @(negedge clk);
    sendAck(9, 1'b0);

    // Timeout replay of sequence 10 (R7)
    base = frCnt;
    sendPkt(4, 8'h5A);
    waitFrames(base + 1);
    checkFrame(base, 10, 4, 8'h5A, "R7");
    repeat (150) @(negedge clk);
    chk(frCnt == base + 1, "R7", "no early replay", frCnt, base + 1);
    waitFrames(base + 2);
    chk(frCnt == base + 2, "R7", "timeout replay count", frCnt, base + 2);
    checkFrame(base + 1, 10, 4, 8'h5A, "R7");
    sendAck(10, 1'b0);

    // Stale negative acknowledge after everything is freed (R8)
    base = frCnt;
    sendAck(10, 1'b1);
    repeat (30) @(negedge clk);
    chk(frCnt == base, "R8", "no replay on stale nak", frCnt, base);

    // Sequence wrap (R2)
    mism = 0;
    wrapField = 16'hFFFF;
    for (int q = 11; q <= 4097; q++) begin
      base = frCnt;
      sendPkt(1, 8'(q));
      waitFrames(base + 1);
      s = q % 4096;
      if ({frB[base % 32][0], frB[base % 32][1]} !== 16'(s)) mism++;
      if (q == 4096) wrapField = {frB[base % 32][0], frB[base % 32][1]};
      if (q == 4097) checkFrame(base, 1, 1, 8'(q), "R2 R3");
      sendAck(s, 1'b0);
    end
    chk(mism == 0, "R2", "sequence mismatches over wrap", mism, 0);
    chk(wrapField == 16'h0000, "R2", "sequence field after 4095", wrapField, 0);

    finish();
  end
endmodule